// File: doc/BRIEF.md
# Chained Converter Serial Read Controller

This block sits on the host side of a string of identical 16-bit sampling converters whose serial ports are cascaded into one line. One request from the host fires a shared convert strobe, so every device in the string samples at the same instant. The controller then waits out the conversion, watching the busy line rise and fall. After busy has dropped it selects the string and clocks the whole chain through in one frame.

During readout the controller drives a serial clock derived from its own system clock by a fixed even divider. It captures one bit per clock period and hands each finished 16-bit word to the host with a one-cycle valid flag and the position of the device that produced it. Position 0 is the device wired closest to the host. The serial clock is held low for the whole conversion and is never released while busy is high. A new request made while a frame is in flight has no effect.

Top module: `chain_reader`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released: cnv_o = 0, cs_no = 1, rd_no = 1, sclk_o = 0 and word_valid_o = 0.
- R2: A start_i pulse while the block is idle produces exactly one high pulse on cnv_o, lasting CNV_W system clock cycles.
- R3: cs_no and rd_no always hold equal values. They stay high until busy_i has risen after the convert pulse and then returned low. They are never low while busy_i is high.
- R4: Each frame produces exactly 16×N_DEV rising edges on sclk_o, and all of them occur while cs_no is low. sclk_o rests low outside readout, and cs_no returns high after the last falling edge.
- R5: sclk_o never rises in a cycle that follows a cycle in which busy_i was high.
- R6: During readout, consecutive rising edges of sclk_o are SCLK_DIV system cycles apart. Elaboration fails unless SCLK_DIV is even and at least 2, and SYS_HZ/SCLK_DIV does not exceed SCLK_MAX_HZ.
- R7: sdata_i is captured at each rising edge of sclk_o, so the devices may change it after falling edges. The first bit of each 16-bit group becomes bit 15 of word_o.
- R8: word_valid_o is a single-cycle pulse after each 16 captured bits, N_DEV times per frame. word_idx_o counts 0,1,…,N_DEV-1 in arrival order, where index 0 is the first 16 bits received (the device nearest the host).
- R9: start_i is ignored while a conversion is in progress or readout is running: cnv_o does not pulse again and the frame yields exactly N_DEV words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a conversion and chain readout |
| busy_i | input | 1 | Conversion in progress, from the converters |
| cnv_o | output | 1 | Shared convert strobe, active high |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read enable, active low |
| sclk_o | output | 1 | Serial clock to the chain |
| sdata_i | input | 1 | Serial data from the nearest converter |
| word_o | output | WORD_W | Assembled word |
| word_valid_o | output | 1 | One-cycle flag: word_o and word_idx_o are valid |
| word_idx_o | output | IDX_W | Chain position of the word, 0 = nearest |

## Verification
A bit counter that is off by one shifts every later word by one bit. It also moves the valid pulse one serial period early or late, so the first word of the frame already mismatches. A pulse counter that ends the frame early or late changes the number of serial clock edges and the number of valid pulses, and this is visible within one frame. A sequencer that leaves the convert or wait states wrongly shows up on cnv_o as an extra or shortened pulse, or as select and clock activity overlapping busy_i, within the same conversion window.

// File: rtl/chain_reader_pkg.sv
package chain_reader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_READ
  } seq_state_e;
endpackage

// File: rtl/chain_reader_seq.sv
module chain_reader_seq
  import chain_reader_pkg::*;
#(
  parameter int CNV_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       busy_i,
  input  logic       frame_done_i,
  output seq_state_e state_o
);
  localparam int CW = $clog2(CNV_W + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CONV;
          cnt_q   <= '0;
        end
        ST_CONV: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(CNV_W - 1)) state_q <= ST_WAIT_HI;
        end
        ST_WAIT_HI: if (busy_i)       state_q <= ST_WAIT_LO;
        ST_WAIT_LO: if (!busy_i)      state_q <= ST_READ;
        ST_READ:    if (frame_done_i) state_q <= ST_IDLE;
        default:                      state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;

  // R9: a request during readout does not restart anything
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && !frame_done_i) |=> state_q == ST_READ);
  // R3: readout is entered only from the wait for busy to fall
  p_read_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_READ) ##1 (state_q == ST_READ) |-> $past(state_q) == ST_WAIT_LO);
endmodule

// File: rtl/chain_reader_sclk.sv
module chain_reader_sclk #(
  parameter int DIV   = 4,
  parameter int TOTAL = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_i,
  input  logic busy_i,
  output logic sclk_o,
  output logic sample_o,
  output logic done_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int PW   = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;
  logic          sclk_q;
  logic          run;

  // clock is frozen whenever busy is high
  assign run = read_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      sclk_q <= 1'b0;
    end else if (!read_i) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      sclk_q <= 1'b0;
    end else if (run) begin
      cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
      if (cnt_q == CW'(HALF - 1)) sclk_q <= 1'b1;
      if (cnt_q == CW'(DIV - 1)) begin
        sclk_q <= 1'b0;
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign sample_o = run && (cnt_q == CW'(HALF - 1));
  assign done_o   = run && (cnt_q == CW'(DIV - 1)) && (pcnt_q == PW'(TOTAL - 1));

  // R4: pulse count never passes the frame length
  p_pulse_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i |-> pcnt_q < PW'(TOTAL));
  // R5: no rising serial clock after a busy cycle
  p_no_sclk_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> !$past(busy_i));
endmodule

// File: rtl/chain_reader_deser.sv
module chain_reader_deser #(
  parameter int WORD_W = 16,
  parameter int N_DEV  = 3,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int BW = $clog2(WORD_W);

  logic [WORD_W-2:0] sr_q;
  logic [BW-1:0]     bcnt_q;
  logic [IDX_W-1:0]  wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      bcnt_q  <= '0;
      wcnt_q  <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        bcnt_q <= '0;
        wcnt_q <= '0;
      end else if (sample_i) begin
        sr_q <= {sr_q[WORD_W-3:0], sd_i};
        if (bcnt_q == BW'(WORD_W - 1)) begin
          bcnt_q  <= '0;
          word_o  <= {sr_q, sd_i};
          valid_o <= 1'b1;
          idx_o   <= wcnt_q;
          wcnt_q  <= wcnt_q + 1'b1;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  // R8: valid is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R8: index stays within the chain
  p_idx_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> idx_o < IDX_W'(N_DEV));
endmodule

// File: rtl/chain_reader.sv
module chain_reader
  import chain_reader_pkg::*;
#(
  parameter int N_DEV       = 3,
  parameter int WORD_W      = 16,
  parameter int CNV_W       = 3,
  parameter int SCLK_DIV    = 4,
  parameter int SYS_HZ      = 100_000_000,
  parameter int SCLK_MAX_HZ = 40_000_000,
  localparam int IDX_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  output logic              cnv_o,
  output logic              cs_no,
  output logic              rd_no,
  output logic              sclk_o,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic [IDX_W-1:0]  word_idx_o
);
  localparam int TOTAL = WORD_W * N_DEV;

  // R6: elaboration guard on divider and rate
  if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_div
    $error("SCLK_DIV must be even and >= 2");
  end
  if ((SYS_HZ / SCLK_DIV) > SCLK_MAX_HZ) begin : g_bad_rate
    $error("serial clock rate above SCLK_MAX_HZ");
  end

  seq_state_e state;
  logic       reading;
  logic       sample;
  logic       frame_done;

  chain_reader_seq #(.CNV_W(CNV_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .busy_i       (busy_i),
    .frame_done_i (frame_done),
    .state_o      (state)
  );

  assign reading = (state == ST_READ);
  assign cnv_o   = (state == ST_CONV);
  assign cs_no   = !reading;
  assign rd_no   = !reading;

  chain_reader_sclk #(.DIV(SCLK_DIV), .TOTAL(TOTAL)) u_sclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .read_i   (reading),
    .busy_i   (busy_i),
    .sclk_o   (sclk_o),
    .sample_o (sample),
    .done_o   (frame_done)
  );

  chain_reader_deser #(.WORD_W(WORD_W), .N_DEV(N_DEV), .IDX_W(IDX_W)) u_deser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (!reading),
    .sample_i (sample),
    .sd_i     (sdata_i),
    .word_o   (word_o),
    .valid_o  (word_valid_o),
    .idx_o    (word_idx_o)
  );

  // R4: serial clock high only inside readout
  p_sclk_in_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  // R3: select and read enable move together
  p_sel_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no == rd_no);
  // R3: select falls only after busy was low
  p_sel_after_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !$past(busy_i));
  // R2: no convert pulse during readout
  p_cnv_not_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_o |-> cs_no);
endmodule

// File: tb/chain_reader_test.sv
module chain_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_DEV      = 3;
  localparam int WORD_W     = 16;
  localparam int CNV_W      = 3;
  localparam int SCLK_DIV   = 4;
  localparam int BUSY_CYC   = 25;
  localparam int IDX_W      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_i = 1'b0;
  logic cnv_o, cs_no, rd_no, sclk_o, sdata_i;
  logic [WORD_W-1:0] word_o;
  logic word_valid_o;
  logic [IDX_W-1:0] word_idx_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_reader #(.N_DEV(N_DEV), .WORD_W(WORD_W), .CNV_W(CNV_W), .SCLK_DIV(SCLK_DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .busy_i(busy_i),
    .cnv_o(cnv_o), .cs_no(cs_no), .rd_no(rd_no), .sclk_o(sclk_o),
    .sdata_i(sdata_i), .word_o(word_o), .word_valid_o(word_valid_o),
    .word_idx_o(word_idx_o)
  );

  // chain model: nearest device at the top, shifts after falling edges
  logic [WORD_W*N_DEV-1:0] chain = '0;
  assign sdata_i = chain[WORD_W*N_DEV-1];
  always @(negedge sclk_o) if (!cs_no) chain <= chain << 1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [IDX_W+WORD_W-1:0] exp_q[$];

  int rises = 0, busy_rises = 0, per_bad = 0, cnv_rises = 0, sel_busy = 0;
  int n_valid = 0, cnv_len = 0, cnv_w_seen = 0, cyc = 0, last_rise = -1;
  logic sclk_p = 1'b0, cnv_p = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected words and watches edge timing
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk_o && !sclk_p) begin
        rises++;
        if (busy_i) busy_rises++;
        if (last_rise >= 0 && (cyc - last_rise) != SCLK_DIV) per_bad++;
        last_rise = cyc;
      end
      if (cs_no) last_rise = -1;
      if (cnv_o && !cnv_p) begin cnv_rises++; cnv_len = 0; end
      if (cnv_o) cnv_len++;
      if (!cnv_o && cnv_p) cnv_w_seen = cnv_len;
      if ((!cs_no && busy_i) || (cs_no != rd_no)) sel_busy++;
      if (word_valid_o) begin
        n_valid++;
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected word", int'(word_o), -1);
        end else begin
          logic [IDX_W+WORD_W-1:0] e;
          e = exp_q.pop_front();
          chk(word_o == e[WORD_W-1:0], "R7 word data", int'(word_o), int'(e[WORD_W-1:0]));
          chk(word_idx_o == e[IDX_W+WORD_W-1:WORD_W], "R8 word index",
              int'(word_idx_o), int'(e[IDX_W+WORD_W-1:WORD_W]));
        end
      end
    end
    sclk_p = sclk_o;
    cnv_p  = cnv_o;
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // driver: loads chain, pushes expectations, plays the converter busy line
  task automatic run_frame(input logic [WORD_W-1:0] w0, w1, w2, input bit inject);
    chain = {w0, w1, w2};
    exp_q.push_back({2'd0, w0});
    exp_q.push_back({2'd1, w1});
    exp_q.push_back({2'd2, w2});
    rises = 0; busy_rises = 0; per_bad = 0; cnv_rises = 0;
    sel_busy = 0; n_valid = 0; cnv_w_seen = 0;
    pulse_start();
    while (!cnv_o) @(negedge clk);
    while (cnv_o) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(cs_no && !sclk_o, "R3 no select before busy", int'(cs_no), 1);
    busy_i = 1'b1;
    if (inject) begin repeat (4) @(negedge clk); pulse_start(); end // R9
    repeat (BUSY_CYC) @(negedge clk);
    busy_i = 1'b0;
    while (cs_no) @(negedge clk);
    if (inject) begin repeat (9) @(negedge clk); pulse_start(); end // R9
    while (!cs_no) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rises == WORD_W*N_DEV, "R4 sclk edge count", rises, WORD_W*N_DEV);
    chk(!sclk_o, "R4 sclk idle low", int'(sclk_o), 0);
    chk(busy_rises == 0, "R5 sclk rise while busy", busy_rises, 0);
    chk(per_bad == 0, "R6 sclk period", per_bad, 0);
    chk(sel_busy == 0, "R3 select during busy", sel_busy, 0);
    chk(cnv_w_seen == CNV_W, "R2 convert width", cnv_w_seen, CNV_W);
    chk(cnv_rises == 1, "R9 convert pulses per frame", cnv_rises, 1);
    chk(n_valid == N_DEV, "R8 words per frame", n_valid, N_DEV);
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!cnv_o && cs_no && rd_no && !sclk_o && !word_valid_o, "R1 in reset",
        int'({cnv_o, cs_no, rd_no, sclk_o, word_valid_o}), 5'b01100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cnv_o && cs_no && rd_no && !sclk_o && !word_valid_o, "R1 after reset",
        int'({cnv_o, cs_no, rd_no, sclk_o, word_valid_o}), 5'b01100);
    run_frame(16'h8001, 16'h7FFE, 16'h1234, 1'b0);
    run_frame(16'hFFFF, 16'h0000, 16'hFFFF, 1'b1);
    run_frame(16'hA5C3, 16'h3C5A, 16'h0001, 1'b1);
    run_frame(16'h0000, 16'h8000, 16'hFFFE, 1'b0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end
endmodule